// File: doc/BRIEF.md
# Universal Bus Transceiver Datapath

This block moves data between an A bus and a B bus in both directions at once. Each direction has three controls per half: an active-low output enable, a latch enable and a capture strobe. Each bit holds one storage register per direction. Together the latch enable and the capture strobe pick one of three behaviours:

- **Transparent:** the output follows the input in the same cycle.
- **Latched:** the output holds the last value that passed through.
- **Clocked:** the output takes a new value only on a clock edge where the strobe is set.

The bus is split into halves, two 9-bit halves by default. In split mode each half obeys its own controls. In wide mode the controls of half 0 steer every bit, and the controls of the other halves have no effect.

Tristate drivers are not built into the block. Each bus output is a value vector plus a per-bit drive-enable vector, and the pad ring turns these into real tristate pins. An override input lets a test wrapper take over both buses, with its own values and enables. The storage registers keep working during the override, so the normal data path is not disturbed.

All storage runs on one system clock with a synchronous active-high reset. The latch and the capture strobe act as synchronous write enables. The "transparent" path is combinational from input to output.

Top module: `ubt_xcvr`

## Requirements
- R1: A clock edge with `rst` high clears both storage registers to zero. Afterwards, with latch enables and strobes low and enables active (`oe_*_n`=0), all value bits read 0 and all drive-enable bits read 1.
- R2: When a half's latch enable is 1, that half's output value equals the opposite bus input in the same cycle.
- R3: When a latch enable falls from 1 to 0, the output holds the input value that was present at the last clock edge with the latch enable at 1.
- R4: When the latch enable is 0 and the capture strobe is 1 at a clock edge, the output shows the input captured at that edge from the next cycle on.
- R5: When the latch enable and the capture strobe are both 0, the output does not change, whatever the input does.
- R6: Each bit of a drive-enable vector is 1 exactly when the active-low enable of its half and direction is 0. Value ports carry the path value even while the enable bits are 0.
- R7: The A-to-B controls (`*_ab`) act only on the B outputs, and the B-to-A controls (`*_ba`) act only on the A outputs.
- R8: With `wide_mode`=0, half h (bits h*9 to h*9+8) uses only its own control bits [h].
- R9: With `wide_mode`=1, control bits [0] steer all halves, and control bits [1] have no effect on any output.
- R10: While `tst_en`=1, `a_val`, `a_oe`, `b_val` and `b_oe` equal `tst_a_val`, `tst_a_oe`, `tst_b_val` and `tst_b_oe`.
- R11: Storage updates continue while `tst_en`=1, so once it falls the outputs show the normal path result, including captures made during the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1: half 0 controls steer all bits |
| a_in | input | 18 | A bus receive data |
| b_in | input | 18 | B bus receive data |
| oe_ab_n | input | 2 | B drive enable per half, active low |
| le_ab | input | 2 | A-to-B latch enable per half |
| cap_ab | input | 2 | A-to-B capture strobe per half |
| oe_ba_n | input | 2 | A drive enable per half, active low |
| le_ba | input | 2 | B-to-A latch enable per half |
| cap_ba | input | 2 | B-to-A capture strobe per half |
| tst_en | input | 1 | Test override select |
| tst_a_val | input | 18 | Override value for the A bus |
| tst_a_oe | input | 18 | Override drive enables for the A bus |
| tst_b_val | input | 18 | Override value for the B bus |
| tst_b_oe | input | 18 | Override drive enables for the B bus |
| a_val | output | 18 | A bus drive value |
| a_oe | output | 18 | A bus per-bit drive enable |
| b_val | output | 18 | B bus drive value |
| b_oe | output | 18 | B bus per-bit drive enable |

## Verification
A capture strobe can arrive in the same cycle as the latch enable, and a capture can land while the test override owns the outputs. Random stimulus sets the strobe, the latch enable and `tst_en` independently in every cycle, so all of these overlaps occur often. Directed steps also place a capture inside an override window, then release the override and read the captured value. Each case is judged against a bench model. In that model the latch enable wins on the output side and either control writes storage. The model applies the overridden outputs while its storage keeps updating underneath.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int UBT_HALF_W     = 9;
    localparam int UBT_NUM_HALVES = 2;

    // Per-half, per-direction control bundle
    typedef struct packed {
        logic oe_n;   // active-low drive enable
        logic le;     // transparent when high
        logic cap;    // capture strobe when le is low
    } dir_ctl_t;

    function automatic dir_ctl_t pack_ctl(input logic oe_n, input logic le, input logic cap);
        dir_ctl_t c;
        c.oe_n = oe_n;
        c.le   = le;
        c.cap  = cap;
        return c;
    endfunction

    // Storage write condition: transparent tracking or a strobe
    function automatic logic store_wr(input dir_ctl_t c);
        return c.le | c.cap;
    endfunction

endpackage

// File: rtl/ubt_ctl_route.sv
module ubt_ctl_route
    import ubt_pkg::*;
#(
    parameter int NUM_HALVES = UBT_NUM_HALVES
) (
    input  logic                       wide_mode,
    input  dir_ctl_t [NUM_HALVES-1:0]  raw,
    output dir_ctl_t [NUM_HALVES-1:0]  eff
);
    assign eff[0] = raw[0];

    for (genvar h = 1; h < NUM_HALVES; h++) begin : g_half
        assign eff[h] = wide_mode ? raw[0] : raw[h];
    end
endmodule

// File: rtl/ubt_store_lane.sv
module ubt_store_lane
    import ubt_pkg::*;
#(
    parameter int W = UBT_HALF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_val,
    output logic [W-1:0] q_oe
);
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (store_wr(ctl))
            held <= d_in;
    end

    assign q_val = ctl.le ? d_in : held;
    assign q_oe  = {W{~ctl.oe_n}};
endmodule

// File: rtl/ubt_dir.sv
module ubt_dir
    import ubt_pkg::*;
#(
    parameter int HALF_W     = UBT_HALF_W,
    parameter int NUM_HALVES = UBT_NUM_HALVES,
    localparam int BUS_W     = HALF_W * NUM_HALVES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wide_mode,
    input  logic [NUM_HALVES-1:0]  oe_n,
    input  logic [NUM_HALVES-1:0]  le,
    input  logic [NUM_HALVES-1:0]  cap,
    input  logic [BUS_W-1:0]       src,
    output logic [BUS_W-1:0]       out_val,
    output logic [BUS_W-1:0]       out_oe
);
    dir_ctl_t [NUM_HALVES-1:0] raw_ctl;
    dir_ctl_t [NUM_HALVES-1:0] eff_ctl;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_pack
        assign raw_ctl[h] = pack_ctl(oe_n[h], le[h], cap[h]);
    end

    ubt_ctl_route #(.NUM_HALVES(NUM_HALVES)) u_route (
        .wide_mode (wide_mode),
        .raw       (raw_ctl),
        .eff       (eff_ctl)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_lane
        ubt_store_lane #(.W(HALF_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctl   (eff_ctl[h]),
            .d_in  (src[h*HALF_W +: HALF_W]),
            .q_val (out_val[h*HALF_W +: HALF_W]),
            .q_oe  (out_oe[h*HALF_W +: HALF_W])
        );
    end
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int HALF_W     = UBT_HALF_W,
    parameter int NUM_HALVES = UBT_NUM_HALVES,
    localparam int BUS_W     = HALF_W * NUM_HALVES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wide_mode,
    input  logic [BUS_W-1:0]       a_in,
    input  logic [BUS_W-1:0]       b_in,
    input  logic [NUM_HALVES-1:0]  oe_ab_n,
    input  logic [NUM_HALVES-1:0]  le_ab,
    input  logic [NUM_HALVES-1:0]  cap_ab,
    input  logic [NUM_HALVES-1:0]  oe_ba_n,
    input  logic [NUM_HALVES-1:0]  le_ba,
    input  logic [NUM_HALVES-1:0]  cap_ba,
    input  logic                   tst_en,
    input  logic [BUS_W-1:0]       tst_a_val,
    input  logic [BUS_W-1:0]       tst_a_oe,
    input  logic [BUS_W-1:0]       tst_b_val,
    input  logic [BUS_W-1:0]       tst_b_oe,
    output logic [BUS_W-1:0]       a_val,
    output logic [BUS_W-1:0]       a_oe,
    output logic [BUS_W-1:0]       b_val,
    output logic [BUS_W-1:0]       b_oe
);
    logic [BUS_W-1:0] ab_val, ab_oe, ba_val, ba_oe;

    // A to B direction drives the B bus
    ubt_dir #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_ab (
        .clk       (clk),
        .rst       (rst),
        .wide_mode (wide_mode),
        .oe_n      (oe_ab_n),
        .le        (le_ab),
        .cap       (cap_ab),
        .src       (a_in),
        .out_val   (ab_val),
        .out_oe    (ab_oe)
    );

    // B to A direction drives the A bus
    ubt_dir #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_ba (
        .clk       (clk),
        .rst       (rst),
        .wide_mode (wide_mode),
        .oe_n      (oe_ba_n),
        .le        (le_ba),
        .cap       (cap_ba),
        .src       (b_in),
        .out_val   (ba_val),
        .out_oe    (ba_oe)
    );

    // Test wrapper override: storage keeps running underneath
    always_comb begin
        if (tst_en) begin
            a_val = tst_a_val;
            a_oe  = tst_a_oe;
            b_val = tst_b_val;
            b_oe  = tst_b_oe;
        end else begin
            a_val = ba_val;
            a_oe  = ba_oe;
            b_val = ab_val;
            b_oe  = ab_oe;
        end
    end
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int HALF_W     = 9,
    parameter int NUM_HALVES = 2,
    localparam int BUS_W     = HALF_W * NUM_HALVES
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wide_mode,
    input logic [BUS_W-1:0]      a_in,
    input logic [NUM_HALVES-1:0] oe_ab_n,
    input logic [NUM_HALVES-1:0] le_ab,
    input logic [NUM_HALVES-1:0] cap_ab,
    input logic [NUM_HALVES-1:0] oe_ba_n,
    input logic                  tst_en,
    input logic [BUS_W-1:0]      tst_a_oe,
    input logic [BUS_W-1:0]      tst_b_val,
    input logic [BUS_W-1:0]      a_oe,
    input logic [BUS_W-1:0]      b_val,
    input logic [BUS_W-1:0]      b_oe
);
    assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
        (!tst_en && le_ab[0]) |-> b_val[HALF_W-1:0] == a_in[HALF_W-1:0]);

    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (!tst_en && !le_ab[0] && cap_ab[0]) |=>
        (tst_en || le_ab[0] || b_val[HALF_W-1:0] == $past(a_in[HALF_W-1:0])));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!tst_en && !le_ab[0] && !cap_ab[0]) |=>
        (tst_en || le_ab[0] || $stable(b_val[HALF_W-1:0])));

    assert_drive_en_R6: assert property (@(posedge clk) disable iff (rst)
        !tst_en |-> a_oe[HALF_W-1:0] == {HALF_W{~oe_ba_n[0]}});

    assert_override_R10: assert property (@(posedge clk) disable iff (rst)
        tst_en |-> (b_val == tst_b_val && a_oe == tst_a_oe));

    if (NUM_HALVES > 1) begin : g_wide
        assert_wide_oe_R9: assert property (@(posedge clk) disable iff (rst)
            (!tst_en && wide_mode) |-> b_oe[2*HALF_W-1:HALF_W] == {HALF_W{~oe_ab_n[0]}});

        assert_wide_pass_R9: assert property (@(posedge clk) disable iff (rst)
            (!tst_en && wide_mode && le_ab[0]) |->
            b_val[2*HALF_W-1:HALF_W] == a_in[2*HALF_W-1:HALF_W]);
    end
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wide_mode (wide_mode),
    .a_in      (a_in),
    .oe_ab_n   (oe_ab_n),
    .le_ab     (le_ab),
    .cap_ab    (cap_ab),
    .oe_ba_n   (oe_ba_n),
    .tst_en    (tst_en),
    .tst_a_oe  (tst_a_oe),
    .tst_b_val (tst_b_val),
    .a_oe      (a_oe),
    .b_val     (b_val),
    .b_oe      (b_oe)
);

// File: tb/tb_ubt_xcvr.sv
module tb_ubt_xcvr;
    localparam int HW = 9;
    localparam int NH = 2;
    localparam int BW = HW * NH;

    logic clk = 1'b0;
    logic rst;
    logic wide_mode;
    logic [BW-1:0] a_in, b_in;
    logic [NH-1:0] oe_ab_n, le_ab, cap_ab, oe_ba_n, le_ba, cap_ba;
    logic tst_en;
    logic [BW-1:0] tst_a_val, tst_a_oe, tst_b_val, tst_b_oe;
    logic [BW-1:0] a_val, a_oe, b_val, b_oe;

    logic [BW-1:0] m_ab, m_ba;
    int n_chk = 0;
    int n_bad = 0;
    int seed_dummy;

    always #4 clk = ~clk;

    ubt_xcvr dut (
        .clk(clk), .rst(rst), .wide_mode(wide_mode),
        .a_in(a_in), .b_in(b_in),
        .oe_ab_n(oe_ab_n), .le_ab(le_ab), .cap_ab(cap_ab),
        .oe_ba_n(oe_ba_n), .le_ba(le_ba), .cap_ba(cap_ba),
        .tst_en(tst_en), .tst_a_val(tst_a_val), .tst_a_oe(tst_a_oe),
        .tst_b_val(tst_b_val), .tst_b_oe(tst_b_oe),
        .a_val(a_val), .a_oe(a_oe), .b_val(b_val), .b_oe(b_oe)
    );

    function automatic int half_of(int i, logic wide);
        return wide ? 0 : i / HW;
    endfunction

    function automatic logic [BW-1:0] exp_val(logic [BW-1:0] din, logic [BW-1:0] st,
                                              logic [NH-1:0] le, logic wide);
        logic [BW-1:0] r;
        for (int i = 0; i < BW; i++) r[i] = le[half_of(i, wide)] ? din[i] : st[i];
        return r;
    endfunction

    function automatic logic [BW-1:0] exp_oe(logic [NH-1:0] oen, logic wide);
        logic [BW-1:0] r;
        for (int i = 0; i < BW; i++) r[i] = ~oen[half_of(i, wide)];
        return r;
    endfunction

    function automatic logic [BW-1:0] next_st(logic [BW-1:0] din, logic [BW-1:0] st,
                                              logic [NH-1:0] le, logic [NH-1:0] cp, logic wide);
        logic [BW-1:0] r;
        for (int i = 0; i < BW; i++) begin
            int h = half_of(i, wide);
            r[i] = (le[h] | cp[h]) ? din[i] : st[i];
        end
        return r;
    endfunction

    task automatic cmp(string tag, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Called just after a negedge with inputs already driven
    task automatic step(string tag);
        #2;
        cmp(tag, "b_val", b_val, tst_en ? tst_b_val : exp_val(a_in, m_ab, le_ab, wide_mode));
        cmp(tag, "b_oe",  b_oe,  tst_en ? tst_b_oe  : exp_oe(oe_ab_n, wide_mode));
        cmp(tag, "a_val", a_val, tst_en ? tst_a_val : exp_val(b_in, m_ba, le_ba, wide_mode));
        cmp(tag, "a_oe",  a_oe,  tst_en ? tst_a_oe  : exp_oe(oe_ba_n, wide_mode));
        @(posedge clk);
        if (rst) begin
            m_ab = '0; m_ba = '0;
        end else begin
            m_ab = next_st(a_in, m_ab, le_ab, cap_ab, wide_mode);
            m_ba = next_st(b_in, m_ba, le_ba, cap_ba, wide_mode);
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wide_mode = 0; a_in = '0; b_in = '0;
        oe_ab_n = '0; le_ab = '0; cap_ab = '0;
        oe_ba_n = '0; le_ba = '0; cap_ba = '0;
        tst_en = 0; tst_a_val = '0; tst_a_oe = '0; tst_b_val = '0; tst_b_oe = '0;
    endtask

    function automatic logic [BW-1:0] rnd();
        return BW'($urandom());
    endfunction

    initial begin : watchdog
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [BW-1:0] keep;
        seed_dummy = $urandom(32'h5EED1);
        idle();
        rst = 1;
        m_ab = '0; m_ba = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: cleared storage, enables active
        step("R1");

        // R2: transparent both halves
        le_ab = 2'b11; le_ba = 2'b11; a_in = rnd(); b_in = rnd();
        step("R2");
        // R3: latch closes, input changes
        keep = a_in;
        le_ab = 2'b00; le_ba = 2'b00; a_in = ~keep; b_in = rnd();
        step("R3");
        n_chk++;
        if (b_val !== keep) begin
            n_bad++; $display("FAIL R3 held: actual %h expected %h", b_val, keep);
        end

        // R4: clocked capture
        cap_ab = 2'b11; a_in = rnd();
        step("R4");
        cap_ab = 2'b00; keep = a_in; a_in = rnd();
        step("R4");

        // R5: hold with both controls low
        a_in = rnd(); b_in = rnd();
        step("R5");
        a_in = rnd();
        step("R5");

        // R6: drive enables per half
        oe_ab_n = 2'b01; oe_ba_n = 2'b10;
        step("R6");
        oe_ab_n = 2'b10; oe_ba_n = 2'b11;
        step("R6");
        oe_ab_n = '0; oe_ba_n = '0;

        // R7: only B-to-A strobes, A-to-B side stays put
        cap_ba = 2'b11; b_in = rnd(); a_in = rnd();
        step("R7");
        cap_ba = 2'b00;
        step("R7");

        // R8: split mode, lower half transparent only
        le_ab = 2'b01; a_in = rnd();
        step("R8");
        le_ab = 2'b10; cap_ba = 2'b01; b_in = rnd();
        step("R8");
        le_ab = '0; cap_ba = '0;
        step("R8");

        // R9: wide mode, upper-half controls ignored
        wide_mode = 1; le_ab = 2'b10; cap_ab = 2'b10; oe_ab_n = 2'b10; a_in = rnd();
        step("R9");
        step("R9");
        le_ab = 2'b01; oe_ab_n = 2'b01; a_in = rnd();
        step("R9");
        wide_mode = 0; le_ab = '0; cap_ab = '0; oe_ab_n = '0;

        // R10: override with a capture underneath
        tst_en = 1; tst_a_val = rnd(); tst_a_oe = rnd(); tst_b_val = rnd(); tst_b_oe = rnd();
        cap_ab = 2'b11; a_in = rnd(); keep = a_in;
        step("R10");
        // R11: release, captured value visible
        tst_en = 0; cap_ab = '0; a_in = rnd();
        step("R11");
        n_chk++;
        if (b_val !== keep) begin
            n_bad++; $display("FAIL R11 capture: actual %h expected %h", b_val, keep);
        end

        // Random mix
        for (int k = 0; k < 600; k++) begin
            wide_mode = ($urandom() % 4) == 0;
            a_in = rnd(); b_in = rnd();
            oe_ab_n = NH'($urandom()); oe_ba_n = NH'($urandom());
            le_ab = NH'($urandom()) & NH'($urandom());
            le_ba = NH'($urandom()) & NH'($urandom());
            cap_ab = NH'($urandom()); cap_ba = NH'($urandom());
            tst_en = ($urandom() % 6) == 0;
            tst_a_val = rnd(); tst_a_oe = rnd(); tst_b_val = rnd(); tst_b_oe = rnd();
            if (tst_en) step("R10");
            else if (wide_mode) step("R9");
            else step("R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule